// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor's execute stage and decides, at each instruction boundary, whether the flow of instructions is broken by an exception or an interrupt. It watches seven event lines: undefined instruction, software interrupt, instruction-fetch abort, data abort, address-range exception, normal interrupt request and fast interrupt request. It also watches the processor's own reset, which it treats as the eighth and strongest event. When an event wins, the block produces everything the core needs to enter the handler in one registered cycle. That covers the target mode, the new interrupt-disable flags, the vector address, a write strobe for the target mode's link register, and the status/PC word to be written there.

While its reset input is low, the block holds the core idle. When reset is released, the first clock edge performs a reset entry: supervisor mode, both disable flags set, vector zero. After that, the core pulses `insn_end` at the end of every instruction. The block samples all events and masks on that edge only. Interrupt requests are level inputs, and each is masked by its own disable flag as currently held by the core. At most one cause is taken per boundary, chosen by a fixed priority.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, `hold` is 1 and `take` and `link_we` are 0.
- R2: At the first rising edge after `rst_n` goes high, the block takes a reset entry. `take` is 1, `vec_addr` is 0, `new_mode` is 3 (supervisor), and `new_i` and `new_f` are both 1. `hold` is 0 from then on.
- R3: The vector address is four times the cause code. The codes are: reset 0, undefined 1, software interrupt 2, fetch abort 3, data abort 4, address exception 5, IRQ 6, FIQ 7.
- R4: Mode encoding is user 0, FIQ 1, IRQ 2, supervisor 3. An IRQ entry sets `new_mode` to 2 and an FIQ entry sets it to 1. Every other entry sets it to 3.
- R5: Every entry sets `new_i` to 1. `new_f` is 1 for reset and FIQ entries. For every other entry, `new_f` equals `cur_f` as it was at the boundary.
- R6: On every entry, `link_we` is 1 together with `take`, and `link_word` carries the state sampled at the boundary. `cur_i` is at bit PC_W+3 and `cur_f` at bit PC_W+2. `cur_pc` occupies bits PC_W+1..2 and `cur_mode` bits 1..0. The word is destined for the link register of `new_mode`.
- R7: Events are sampled only on an edge where `insn_end` is 1. With `insn_end` at 0, no entry is taken whatever the event lines show.
- R8: An IRQ request is ignored while `cur_i` is 1. An FIQ request is ignored while `cur_f` is 1.
- R9: When unmasked FIQ and IRQ requests are present at the same boundary, the FIQ is taken.
- R10: The full priority, highest first, is: reset, data abort, address exception, FIQ, IRQ, fetch abort, undefined instruction, software interrupt.
- R11: `take` is a single-cycle pulse per accepted boundary. It falls on the next edge unless that edge is itself an accepted boundary.
- R12: All entry outputs are registered. They appear on the rising edge that samples the boundary and are stable for the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low processor reset, asynchronous assert |
| insn_end | input | 1 | High on the cycle that ends an instruction |
| ev_undef | input | 1 | Undefined instruction detected |
| ev_swi | input | 1 | Software interrupt instruction executed |
| ev_pabt | input | 1 | Abort on instruction fetch |
| ev_dabt | input | 1 | Abort on data access |
| ev_addr | input | 1 | Address outside the legal range |
| irq_req | input | 1 | Normal interrupt request, level |
| fiq_req | input | 1 | Fast interrupt request, level |
| cur_mode | input | 2 | Current mode (R4 encoding) |
| cur_i | input | 1 | Current IRQ disable flag |
| cur_f | input | 1 | Current FIQ disable flag |
| cur_pc | input | PC_W | Current program counter word |
| hold | output | 1 | Core must stay idle |
| take | output | 1 | One-cycle pulse: an entry is taken |
| link_we | output | 1 | Write strobe for the target mode's link register |
| link_word | output | PC_W+4 | Saved status and PC word |
| new_mode | output | 2 | Mode to enter |
| new_i | output | 1 | New IRQ disable flag |
| new_f | output | 1 | New FIQ disable flag |
| vec_addr | output | VEC_W | Vector address to load into the PC |

## Verification
Each entry result is due exactly one rising edge after the boundary that caused it. The bench drives all inputs on the falling edge and reads every output at the next falling edge, so the values it sees are those registered by the single edge in between. It then leaves one idle cycle and confirms at the following falling edge that `take` has dropped. For the reset entry, the check is made at the falling edge after the first rising edge following release.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_FIQ  = 2'd1,
    MODE_IRQ  = 2'd2,
    MODE_SVC  = 2'd3
  } mode_e;

  // Cause codes double as vector indices (vector = code * 4).
  typedef enum logic [2:0] {
    CS_RESET = 3'd0,
    CS_UNDEF = 3'd1,
    CS_SWI   = 3'd2,
    CS_PABT  = 3'd3,
    CS_DABT  = 3'd4,
    CS_ADDR  = 3'd5,
    CS_IRQ   = 3'd6,
    CS_FIQ   = 3'd7
  } cause_e;

  localparam int NUM_CAUSE = 8;

  // Rank 0 is the strongest cause (R10).
  function automatic cause_e rank_cause(input int rank);
    case (rank)
      0:       return CS_RESET;
      1:       return CS_DABT;
      2:       return CS_ADDR;
      3:       return CS_FIQ;
      4:       return CS_IRQ;
      5:       return CS_PABT;
      6:       return CS_UNDEF;
      default: return CS_SWI;
    endcase
  endfunction

endpackage

// File: rtl/exc_reset_ctl.sv
module exc_reset_ctl (
  input  logic clk,
  input  logic rst_n,
  output logic hold
);
  typedef enum logic {ST_HOLD = 1'b0, ST_RUN = 1'b1} rst_st_e;
  rst_st_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HOLD;
    else        st_q <= ST_RUN;
  end

  assign hold = (st_q == ST_HOLD);
endmodule

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
  import exc_entry_pkg::*;
#(
  parameter int NC = NUM_CAUSE
) (
  input  logic [NC-1:0] req,
  output logic          any,
  output cause_e        sel
);
  // Walk from weakest to strongest so the strongest active cause remains.
  always_comb begin
    any = 1'b0;
    sel = CS_SWI;
    for (int r = NC - 1; r >= 0; r--) begin
      if (req[int'(rank_cause(r))]) begin
        any = 1'b1;
        sel = rank_cause(r);
      end
    end
  end
endmodule

// File: rtl/exc_entry_table.sv
module exc_entry_table
  import exc_entry_pkg::*;
#(
  parameter int VEC_W = 26
) (
  input  cause_e           cause,
  input  logic             cur_f,
  output mode_e            mode,
  output logic             f_out,
  output logic [VEC_W-1:0] vec
);
  localparam int CODE_W = $bits(cause_e) + 2;

  always_comb begin
    case (cause)
      CS_IRQ:  mode = MODE_IRQ;
      CS_FIQ:  mode = MODE_FIQ;
      default: mode = MODE_SVC;
    endcase
    f_out = (cause == CS_RESET || cause == CS_FIQ) ? 1'b1 : cur_f;
    vec   = VEC_W'(CODE_W'({cause, 2'b00}));
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int PC_W  = 24,
  parameter int VEC_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_end,
  input  logic              ev_undef,
  input  logic              ev_swi,
  input  logic              ev_pabt,
  input  logic              ev_dabt,
  input  logic              ev_addr,
  input  logic              irq_req,
  input  logic              fiq_req,
  input  logic [1:0]        cur_mode,
  input  logic              cur_i,
  input  logic              cur_f,
  input  logic [PC_W-1:0]   cur_pc,
  output logic              hold,
  output logic              take,
  output logic              link_we,
  output logic [PC_W+3:0]   link_word,
  output logic [1:0]        new_mode,
  output logic              new_i,
  output logic              new_f,
  output logic [VEC_W-1:0]  vec_addr
);
  localparam int LW = PC_W + 4;

  logic [NUM_CAUSE-1:0] req;
  logic                 any;
  logic                 fire;
  cause_e               win;
  mode_e                tgt_mode;
  logic                 tgt_f;
  logic [VEC_W-1:0]     tgt_vec;
  logic                 boundary;

  exc_reset_ctl u_rst (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (hold)
  );

  assign boundary = insn_end && !hold;

  always_comb begin
    req                = '0;
    req[int'(CS_RESET)] = hold;
    req[int'(CS_UNDEF)] = boundary && ev_undef;
    req[int'(CS_SWI)]   = boundary && ev_swi;
    req[int'(CS_PABT)]  = boundary && ev_pabt;
    req[int'(CS_DABT)]  = boundary && ev_dabt;
    req[int'(CS_ADDR)]  = boundary && ev_addr;
    req[int'(CS_IRQ)]   = boundary && irq_req && !cur_i;
    req[int'(CS_FIQ)]   = boundary && fiq_req && !cur_f;
  end

  exc_cause_arb #(.NC(NUM_CAUSE)) u_arb (
    .req(req),
    .any(any),
    .sel(win)
  );

  exc_entry_table #(.VEC_W(VEC_W)) u_tab (
    .cause(win),
    .cur_f(cur_f),
    .mode (tgt_mode),
    .f_out(tgt_f),
    .vec  (tgt_vec)
  );

  assign fire = any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take      <= 1'b0;
      link_we   <= 1'b0;
      link_word <= '0;
      new_mode  <= 2'(MODE_SVC);
      new_i     <= 1'b1;
      new_f     <= 1'b1;
      vec_addr  <= '0;
    end else begin
      take    <= fire;
      link_we <= fire;
      if (fire) begin
        link_word <= LW'({cur_i, cur_f, cur_pc, cur_mode});
        new_mode  <= 2'(tgt_mode);
        new_i     <= 1'b1;
        new_f     <= tgt_f;
        vec_addr  <= tgt_vec;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int PC_W  = 24,
  parameter int VEC_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             insn_end,
  input logic             irq_req,
  input logic             fiq_req,
  input logic             cur_i,
  input logic             cur_f,
  input logic             hold,
  input logic             take,
  input logic             link_we,
  input logic [1:0]       new_mode,
  input logic             new_i,
  input logic             new_f,
  input logic [VEC_W-1:0] vec_addr
);
  localparam logic [VEC_W-1:0] V_IRQ = VEC_W'(24);
  localparam logic [VEC_W-1:0] V_FIQ = VEC_W'(28);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_idle_in_reset: assert (hold && !take && !link_we)
        else $error("a_r1_idle_in_reset");
    end
  end

  a_r2_reset_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (take && vec_addr == '0 && new_mode == 2'd3 && new_i && new_f));

  a_r5_i_always_set: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> new_i);

  a_r7_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($past(insn_end) || $past(hold)));

  a_r8_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr == V_IRQ) |-> $past(irq_req && !cur_i));

  a_r8_fiq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr == V_FIQ) |-> ($past(fiq_req && !cur_f) && new_f));

  a_r9_fiq_first: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr == V_IRQ) |-> !$past(fiq_req && !cur_f));

  a_r4_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr == V_IRQ) |-> new_mode == 2'd2);
endmodule

bind exc_entry_seq exc_entry_chk #(.PC_W(PC_W), .VEC_W(VEC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .insn_end(insn_end),
  .irq_req (irq_req),
  .fiq_req (fiq_req),
  .cur_i   (cur_i),
  .cur_f   (cur_f),
  .hold    (hold),
  .take    (take),
  .link_we (link_we),
  .new_mode(new_mode),
  .new_i   (new_i),
  .new_f   (new_f),
  .vec_addr(vec_addr)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  localparam int PC_W  = 24;
  localparam int VEC_W = 26;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_end = 1'b0;
  logic ev_undef = 0, ev_swi = 0, ev_pabt = 0, ev_dabt = 0, ev_addr = 0;
  logic irq_req = 0, fiq_req = 0;
  logic [1:0] cur_mode = 2'd0;
  logic cur_i = 1'b0, cur_f = 1'b0;
  logic [PC_W-1:0] cur_pc = '0;
  logic hold, take, link_we, new_i, new_f;
  logic [PC_W+3:0] link_word;
  logic [1:0] new_mode;
  logic [VEC_W-1:0] vec_addr;

  int checks = 0;
  int failures = 0;

  exc_entry_seq #(.PC_W(PC_W), .VEC_W(VEC_W)) u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .insn_end(insn_end),
    .ev_undef(ev_undef), .ev_swi(ev_swi), .ev_pabt(ev_pabt),
    .ev_dabt(ev_dabt), .ev_addr(ev_addr), .irq_req(irq_req),
    .fiq_req(fiq_req), .cur_mode(cur_mode), .cur_i(cur_i), .cur_f(cur_f),
    .cur_pc(cur_pc), .hold(hold), .take(take), .link_we(link_we),
    .link_word(link_word), .new_mode(new_mode), .new_i(new_i),
    .new_f(new_f), .vec_addr(vec_addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference priority (R10) with masking (R8): returns cause code or -1.
  function automatic int ref_cause(input bit u, s, p, d, a, irq, fiq, i, f);
    if (d) return 4;
    if (a) return 5;
    if (fiq && !f) return 7;
    if (irq && !i) return 6;
    if (p) return 3;
    if (u) return 1;
    if (s) return 2;
    return -1;
  endfunction

  function automatic longint ref_word(input bit i, f, input longint pc, input int md);
    return (longint'(i) << (PC_W + 3)) | (longint'(f) << (PC_W + 2)) | (pc << 2) | longint'(md);
  endfunction

  task automatic clear_ev();
    {ev_undef, ev_swi, ev_pabt, ev_dabt, ev_addr, irq_req, fiq_req} = '0;
  endtask

  // Check an entry taken with given expected code; inputs already driven.
  task automatic check_entry(input int code, input bit i, f, input longint pc, input int md);
    int emode;
    bit ef;
    emode = (code == 6) ? 2 : (code == 7) ? 1 : 3;
    ef = (code == 0 || code == 7) ? 1'b1 : f;
    chk(take == 1'b1, "R12 take at next edge", take, 1);
    chk(vec_addr == VEC_W'(code * 4), "R3 vector", vec_addr, code * 4);
    chk(new_mode == 2'(emode), "R4 mode", new_mode, emode);
    chk(new_i == 1'b1 && new_f == ef, "R5 flags", {new_i, new_f}, {1'b1, ef});
    chk(link_we == 1'b1 && link_word == (PC_W+4)'(ref_word(i, f, pc, md)),
        "R6 link save", link_word, ref_word(i, f, pc, md));
  endtask

  // One boundary: drive at negedge, sample after the edge, then one idle cycle.
  task automatic boundary(input int combo);
    int code;
    bit u, s, p, d, a, irq, fiq, i, f;
    longint pc;
    {f, i, fiq, irq, a, d, p, s, u} = 9'(combo);
    pc = longint'((combo * 32'h2b5 + 7) & ((1 << PC_W) - 1));
    @(negedge clk);
    ev_undef = u; ev_swi = s; ev_pabt = p; ev_dabt = d; ev_addr = a;
    irq_req = irq; fiq_req = fiq; cur_i = i; cur_f = f;
    cur_mode = 2'(combo); cur_pc = PC_W'(pc);
    insn_end = 1'b1;
    @(negedge clk);
    code = ref_cause(u, s, p, d, a, irq, fiq, i, f);
    if (code < 0) chk(take == 1'b0 && link_we == 1'b0, "R8 no entry when masked/idle", take, 0);
    else begin
      check_entry(code, i, f, pc, combo & 3);
      if (irq && fiq && !i && !f && !d && !a)
        chk(vec_addr == VEC_W'(28), "R9 fiq over irq", vec_addr, 28);
    end
    insn_end = 1'b0;
    clear_ev();
    @(negedge clk);
    chk(take == 1'b0, "R11 single pulse", take, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: idle in reset even with every event raised.
    {ev_undef, ev_swi, ev_pabt, ev_dabt, ev_addr, irq_req, fiq_req} = '1;
    insn_end = 1'b1;
    repeat (3) @(negedge clk);
    chk(hold == 1'b1 && take == 1'b0 && link_we == 1'b0, "R1 reset idle", {hold, take, link_we}, 3'b100);
    clear_ev();
    insn_end = 1'b0;
    cur_pc = PC_W'(24'h12345); cur_mode = 2'd2; cur_i = 1'b0; cur_f = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset entry at first edge after release.
    chk(hold == 1'b0, "R2 hold released", hold, 0);
    check_entry(0, 1'b0, 1'b1, 64'h12345, 2);
    @(negedge clk);
    chk(take == 1'b0, "R11 reset pulse ends", take, 0);

    // R7: events without a boundary are ignored.
    cur_i = 1'b0; cur_f = 1'b0;
    {ev_undef, ev_swi, ev_pabt, ev_dabt, ev_addr, irq_req, fiq_req} = '1;
    repeat (4) begin
      @(negedge clk);
      chk(take == 1'b0, "R7 no sample without insn_end", take, 0);
    end
    clear_ev();

    // R3 R4 R5 R6 R8 R9 R10: sweep all event and mask combinations.
    for (int c = 0; c < 512; c++) boundary(c);

    // R8 R9: IRQ pending during an FIQ handler waits for the masks to clear.
    @(negedge clk);
    cur_i = 1'b0; cur_f = 1'b0; fiq_req = 1'b1; irq_req = 1'b1; insn_end = 1'b1;
    cur_pc = PC_W'(24'h000400); cur_mode = 2'd0;
    @(negedge clk);
    chk(take && vec_addr == VEC_W'(28), "R9 fiq taken first", vec_addr, 28);
    cur_mode = new_mode; cur_i = new_i; cur_f = new_f; fiq_req = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(take == 1'b0, "R8 irq held off in fiq handler", take, 0);
    end
    cur_i = 1'b0; cur_f = 1'b0; cur_mode = 2'd0;
    @(negedge clk);
    chk(take && vec_addr == VEC_W'(24) && new_mode == 2'd2,
        "R8 irq taken after return", vec_addr, 24);
    insn_end = 1'b0; clear_ev();
    @(negedge clk);

    // R1 R2: reset in mid-run.
    rst_n = 1'b0; insn_end = 1'b1; ev_swi = 1'b1;
    @(negedge clk);
    chk(hold && !take, "R1 mid-run reset idle", {hold, take}, 2'b10);
    cur_i = 1'b1; cur_f = 1'b0; cur_pc = PC_W'(24'h00abcd); cur_mode = 2'd3;
    insn_end = 1'b0; clear_ev();
    rst_n = 1'b1;
    @(negedge clk);
    check_entry(0, 1'b1, 1'b0, 64'h00abcd, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule